// File: doc/BRIEF.md
# Power-Down and Soft-Reset Controller

This block sits at the top of a video-decoder-style chip and holds one control register. It decides whether the chip is powered down. The decision comes either from an external active-low power-down pin or from a register bit, and a priority bit in the same register chooses which of the two counts. While the chip is powered down, the block gates off the digital-core clock through a glitch-free latch gate and asks the analog blocks to drop into a low-current mode. The register port itself keeps running, so the power-down can be undone by another write.

The block also runs a timed chip reset. Two things start it: a write of 1 to the self-clearing reset bit, or the hardware reset pin. That pin asserts asynchronously and releases through a two-stage synchronizer. For a fixed number of cycles, the resettable register fields go back to their defaults and the reset bit reads back as 1. During that window the bus front end is told to refuse transfers with a no-acknowledge. The two general-purpose bits have no reset value and keep whatever was last written to them. The chip power-on reset (`rst_ni`) also starts this sequence once it is released.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: After `rst_ni` is released, `reset_busy` is 1 from the first clock edge and falls on the edge numbered RST_CYCLES+2. The register at CTRL_ADDR (0x0F) reads 0x00, `core_clk_en` is 1 and `analog_lowpwr` is 0, with `pdn_ni` high.
- R2: While the priority bit (bit 2) is 0, power-down follows `pdn_ni` low. The outputs change on the third clock edge after the pin changes. Register bit 5 has no effect in this mode.
- R3: While bit 2 is 1, bit 5 decides power-down and `pdn_ni` has no effect. The outputs change on the second clock edge after the write.
- R4: In power-down, `core_clk_en` is 0, `core_clk` shows no rising edge and `analog_lowpwr` is 1. Otherwise `core_clk` follows every cycle of `clk`.
- R5: Writes are accepted during power-down, so writing 0 to bit 5 (with bit 2 set) brings the chip back up.
- R6: A write of bit 7 = 1 to CTRL_ADDR while not busy sets `reset_busy` on that edge and holds it for exactly RST_CYCLES cycles. Bit 7 reads back as `reset_busy`.
- R7: A chip reset clears bits 5 and 2 and leaves bits 1:0 unchanged, including their value from before the write that started the reset.
- R8: `wr_nack` is 1, in the same cycle as `wr_en`, for a write that starts a reset and for any write while `reset_busy` or the hardware reset is active. Such refused writes change nothing. Other writes get `wr_nack` = 0.
- R9: `chip_rst_ni` low sets `reset_busy` on the next edge and applies the R7 defaults. After the pin is released, `reset_busy` stays 1 through release edge RST_CYCLES+1 and falls on edge RST_CYCLES+2.
- R10: While `reset_busy` is 1, power-down is suppressed. From the second busy cycle on, `core_clk_en` is 1 and `analog_lowpwr` is 0.
- R11: Writes to any address other than CTRL_ADDR are ignored, and such addresses read 0x00. Bits 6, 4 and 3 of the control register always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, never gated |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| chip_rst_ni | input | 1 | Hardware chip-reset pin, active low |
| pdn_ni | input | 1 | External power-down pin, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| wr_nack | output | 1 | Refuse the current transfer with a no-acknowledge |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, combinational |
| reset_busy | output | 1 | Chip reset window is active |
| core_clk_en | output | 1 | Registered enable of the core clock gate |
| core_clk | output | 1 | Gated digital-core clock |
| analog_lowpwr | output | 1 | Low-current request to the analog blocks |

## Verification
A wrong priority or power-down field shows up on `analog_lowpwr` and `core_clk_en` by the second edge after the write, or by the third edge after a pin change. A gate latch stuck closed, or one that leaks, shows up as a wrong count of `core_clk` edges over a ten-cycle window. A reset counter that is off by one moves the falling edge of `reset_busy` by a cycle, and the bench samples both sides of that edge. A reset that wipes the keep bits, or a refused write that still lands, can be read back through `rd_data` as soon as the window closes.

// File: rtl/prc_pkg.sv
package prc_pkg;
    // Control register width and the bit positions decoded by the bus side
    localparam int CTRL_W   = 8;
    localparam int RST_POS  = 7;
    localparam int PD_POS   = 5;
    localparam int PRIO_POS = 2;
    localparam int KEEP_W   = 2;   // bits KEEP_W-1:0, no reset value on chip reset

    typedef struct packed {
        logic              pd;
        logic              prio;
        logic [KEEP_W-1:0] keep;
    } ctrl_t;

    typedef struct packed {
        logic core_en;
        logic analog_lp;
    } pwr_out_t;
endpackage

// File: rtl/prc_sync.sv
module prc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_ni,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge arst_ni) begin
        if (!arst_ni) sh_q <= {STAGES{RST_VAL}};
        else          sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/prc_ctrl_reg.sv
module prc_ctrl_reg
    import prc_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              hw_rst,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              soft_start,
    output logic              wr_nack,
    output ctrl_t             ctrl,
    output logic [CTRL_W-1:0] rd_data
);
    ctrl_t ctrl_d, ctrl_q;
    logic  hit;
    logic  wr_unused;

    assign hit       = wr_en && (wr_addr == CTRL_ADDR);
    assign wr_unused = ^wr_data;

    always_comb begin
        ctrl_d     = ctrl_q;
        soft_start = 1'b0;
        if (hw_rst) begin
            ctrl_d.pd   = 1'b0;
            ctrl_d.prio = 1'b0;
        end else if (hit && !busy) begin
            if (wr_data[RST_POS]) begin
                soft_start  = 1'b1;
                ctrl_d.pd   = 1'b0;
                ctrl_d.prio = 1'b0;
            end else begin
                ctrl_d.pd   = wr_data[PD_POS];
                ctrl_d.prio = wr_data[PRIO_POS];
                ctrl_d.keep = wr_data[KEEP_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) ctrl_q <= '0;
        else         ctrl_q <= ctrl_d;
    end

    always_comb begin
        wr_nack = wr_en && (busy || hw_rst || (hit && wr_data[RST_POS]));
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_ADDR) begin
            rd_data[RST_POS]    = busy;
            rd_data[PD_POS]     = ctrl_q.pd;
            rd_data[PRIO_POS]   = ctrl_q.prio;
            rd_data[KEEP_W-1:0] = ctrl_q.keep;
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/prc_rst_seq.sv
module prc_rst_seq #(
    parameter int RST_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_ni,
    input  logic hw_rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (hw_rst || start) begin
            seq_d.busy = 1'b1;
            seq_d.cnt  = LOAD;
        end else if (seq_q.busy) begin
            if (seq_q.cnt == '0) seq_d.busy = 1'b0;
            else                 seq_d.cnt  = seq_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '0;
        else         seq_q <= seq_d;
    end

    assign busy = seq_q.busy;
endmodule

// File: rtl/prc_clk_gate.sv
module prc_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    // transparent while clk is low, so the enable settles before the rising edge
    always_latch begin
        if (!clk) en_lat = en;
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl
    import prc_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h0F,
    parameter int                RST_CYCLES = 200000,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              chip_rst_ni,
    input  logic              pdn_ni,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CTRL_W-1:0] wr_data,
    output logic              wr_nack,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CTRL_W-1:0] rd_data,
    output logic              reset_busy,
    output logic              core_clk_en,
    output logic              core_clk,
    output logic              analog_lowpwr
);
    logic     hw_arst_n;
    logic     hw_rel;
    logic     hw_rst;
    logic     pdn_sync;
    logic     soft_start;
    logic     busy;
    logic     pd_req;
    ctrl_t    ctrl_q;
    pwr_out_t out_d, out_q;

    assign hw_arst_n = rst_ni & chip_rst_ni;

    prc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_hw_sync (
        .clk(clk), .arst_ni(hw_arst_n), .d(1'b1), .q(hw_rel)
    );

    prc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pdn_sync (
        .clk(clk), .arst_ni(rst_ni), .d(pdn_ni), .q(pdn_sync)
    );

    assign hw_rst = !hw_rel;

    prc_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_reg (
        .clk        (clk),
        .rst_ni     (rst_ni),
        .hw_rst     (hw_rst),
        .busy       (busy),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .soft_start (soft_start),
        .wr_nack    (wr_nack),
        .ctrl       (ctrl_q),
        .rd_data    (rd_data)
    );

    prc_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk    (clk),
        .rst_ni (rst_ni),
        .hw_rst (hw_rst),
        .start  (soft_start),
        .busy   (busy)
    );

    always_comb begin
        pd_req = !busy && (ctrl_q.prio ? ctrl_q.pd : !pdn_sync);
        out_d.core_en   = !pd_req;
        out_d.analog_lp = pd_req;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) out_q <= '{core_en: 1'b1, analog_lp: 1'b0};
        else         out_q <= out_d;
    end

    prc_clk_gate u_gate (
        .clk  (clk),
        .en   (out_q.core_en),
        .gclk (core_clk)
    );

    assign reset_busy    = busy;
    assign core_clk_en   = out_q.core_en;
    assign analog_lowpwr = out_q.analog_lp;
endmodule

// File: rtl/prc_chk.sv
module prc_chk
    import prc_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h0F,
    parameter int                RST_CYCLES = 200000
) (
    input logic              clk,
    input logic              rst_ni,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CTRL_W-1:0] wr_data,
    input logic              wr_nack,
    input logic              reset_busy,
    input logic              core_clk_en,
    input logic              analog_lowpwr,
    input logic              hw_rst,
    input ctrl_t             ctrl
);
    int   len_q;
    logic data_unused;

    assign data_unused = ^wr_data;

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)                   len_q <= 0;
        else if (hw_rst || !reset_busy) len_q <= 0;
        else                           len_q <= len_q + 1;
    end

    // R8
    nack_busy_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        wr_en && reset_busy |-> wr_nack);

    // R6
    soft_start_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        wr_en && (wr_addr == CTRL_ADDR) && wr_data[RST_POS] && !reset_busy && !hw_rst
        |=> reset_busy);

    // R6
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        reset_busy |-> len_q < RST_CYCLES);

    // R6
    window_end_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        reset_busy && !hw_rst && len_q == RST_CYCLES - 1 |=> !reset_busy);

    // R7
    defaults_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(reset_busy) |-> !ctrl.pd && !ctrl.prio);

    // R7
    keep_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(reset_busy) |-> ctrl.keep == $past(ctrl.keep));

    // R10
    busy_awake_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        reset_busy && $past(reset_busy) |-> core_clk_en && !analog_lowpwr);
endmodule

bind pwr_rst_ctrl prc_chk #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .RST_CYCLES(RST_CYCLES)
) u_chk (
    .clk           (clk),
    .rst_ni        (rst_ni),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .wr_nack       (wr_nack),
    .reset_busy    (reset_busy),
    .core_clk_en   (core_clk_en),
    .analog_lowpwr (analog_lowpwr),
    .hw_rst        (hw_rst),
    .ctrl          (ctrl_q)
);

// File: tb/pwr_rst_ctrl_test.sv
`timescale 1ns/1ps
module pwr_rst_ctrl_test;
    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       chip_rst_ni = 1'b1;
    logic       pdn_ni = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       wr_nack;
    logic [7:0] rd_addr = 8'h0F;
    logic [7:0] rd_data;
    logic       reset_busy;
    logic       core_clk_en;
    logic       core_clk;
    logic       analog_lowpwr;

    int checks = 0;
    int errors = 0;
    int gedges = 0;
    logic last_nack;

    always #5 clk = ~clk;

    always @(posedge core_clk) gedges = gedges + 1;

    pwr_rst_ctrl #(.RST_CYCLES(N)) uut (
        .clk(clk), .rst_ni(rst_ni), .chip_rst_ni(chip_rst_ni), .pdn_ni(pdn_ni),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_nack(wr_nack),
        .rd_addr(rd_addr), .rd_data(rd_data), .reset_busy(reset_busy),
        .core_clk_en(core_clk_en), .core_clk(core_clk), .analog_lowpwr(analog_lowpwr)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called at a negedge; returns at the negedge after the commit edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        #1 last_nack = wr_nack;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        rd_addr = a;
        #1 v = rd_data;
        rd_addr = 8'h0F;
    endtask

    task automatic count_gated(output int n);
        int start;
        start = gedges;
        step(10);
        n = gedges - start;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        step(3);
        check1("R1 busy in reset", reset_busy, 1'b0);
        rst_ni = 1'b1;
        step(1);
        check1("R1 busy after first edge", reset_busy, 1'b1);
        step(N);
        check1("R1 busy before end", reset_busy, 1'b1);
        step(1);
        check1("R1 busy end", reset_busy, 1'b0);
        rd(8'h0F, v);
        check8("R1 ctrl default", v, 8'h00);
        check1("R1 core_clk_en", core_clk_en, 1'b1);
        check1("R1 analog_lowpwr", analog_lowpwr, 1'b0);
    endtask

    task automatic t_pin_mode;
        int n;
        wr(8'h0F, 8'h20);
        step(2);
        check1("R2 bit5 ignored with prio 0", analog_lowpwr, 1'b0);
        wr(8'h0F, 8'h00);
        pdn_ni = 1'b0;
        step(2);
        check1("R2 pin not yet seen", analog_lowpwr, 1'b0);
        step(1);
        check1("R2 pin power-down", analog_lowpwr, 1'b1);
        check1("R4 core_clk_en off", core_clk_en, 1'b0);
        count_gated(n);
        check8("R4 no gated edges", 8'(n), 8'd0);
        pdn_ni = 1'b1;
        step(3);
        check1("R2 pin release", analog_lowpwr, 1'b0);
        count_gated(n);
        check8("R4 gated clock runs", 8'(n), 8'd10);
    endtask

    task automatic t_reg_mode;
        int n;
        pdn_ni = 1'b0;
        step(3);
        check1("R2 pin down before prio", analog_lowpwr, 1'b1);
        wr(8'h0F, 8'h04);
        step(1);
        check1("R3 pin ignored with prio 1", analog_lowpwr, 1'b0);
        wr(8'h0F, 8'h24);
        check1("R3 not before second edge", analog_lowpwr, 1'b0);
        step(1);
        check1("R3 bit5 power-down", analog_lowpwr, 1'b1);
        check1("R4 core_clk_en off by bit", core_clk_en, 1'b0);
        count_gated(n);
        check8("R4 no gated edges by bit", 8'(n), 8'd0);
        wr(8'h0F, 8'h04);
        check1("R5 write accepted in power-down", last_nack, 1'b0);
        step(1);
        check1("R5 wake by clearing bit5", analog_lowpwr, 1'b0);
        pdn_ni = 1'b1;
        wr(8'h0F, 8'h00);
        step(3);
    endtask

    task automatic t_soft_reset;
        logic [7:0] v;
        wr(8'h0F, 8'h27);
        step(1);
        check1("R3 down before soft reset", core_clk_en, 1'b0);
        wr(8'h0F, 8'h80);
        check1("R8 nack on reset write", last_nack, 1'b1);
        check1("R6 busy on trigger edge", reset_busy, 1'b1);
        rd(8'h0F, v);
        check8("R7 defaults and keep during reset", v, 8'h83);
        step(1);
        check1("R10 core clock on while busy", core_clk_en, 1'b1);
        check1("R10 analog awake while busy", analog_lowpwr, 1'b0);
        wr(8'h0F, 8'h24);
        check1("R8 nack while busy", last_nack, 1'b1);
        step(N - 3);
        check1("R6 busy last cycle", reset_busy, 1'b1);
        step(1);
        check1("R6 self clear", reset_busy, 1'b0);
        rd(8'h0F, v);
        check8("R8 refused write had no effect", v, 8'h03);
        step(1);
        check1("R7 awake after reset", core_clk_en, 1'b1);
    endtask

    task automatic t_plain_writes;
        logic [7:0] v;
        wr(8'h0F, 8'h01);
        check1("R8 no nack on normal write", last_nack, 1'b0);
        wr(8'h10, 8'hFF);
        check1("R8 no nack other address", last_nack, 1'b0);
        rd(8'h0F, v);
        check8("R11 other address write ignored", v, 8'h01);
        rd(8'h10, v);
        check8("R11 other address reads zero", v, 8'h00);
        wr(8'h0F, 8'h5B);
        rd(8'h0F, v);
        check8("R11 reserved bits read zero", v, 8'h03);
        check1("R11 no reset from reserved bits", reset_busy, 1'b0);
    endtask

    task automatic t_hw_reset;
        logic [7:0] v;
        wr(8'h0F, 8'h26);
        step(1);
        check1("R3 down before pin reset", analog_lowpwr, 1'b1);
        chip_rst_ni = 1'b0;
        #1 wr_en = 1'b1; wr_addr = 8'h0F; wr_data = 8'h04;
        #1 check1("R8 nack during pin reset", wr_nack, 1'b1);
        @(negedge clk);
        wr_en = 1'b0;
        check1("R9 busy after pin", reset_busy, 1'b1);
        rd(8'h0F, v);
        check8("R9 defaults keep bits", v, 8'h82);
        step(5);
        check1("R10 awake under pin reset", core_clk_en, 1'b1);
        chip_rst_ni = 1'b1;
        step(N + 1);
        check1("R9 busy before end", reset_busy, 1'b1);
        step(1);
        check1("R9 busy end", reset_busy, 1'b0);
    endtask

    initial begin
        t_reset();
        t_pin_mode();
        t_reg_mode();
        t_soft_reset();
        t_plain_writes();
        t_hw_reset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule